// File: doc/BRIEF.md
# Serially Configured Two-Cell Logic Fabric

This block is a very small programmable logic fabric. It has two logic cells and one routing stage between them. Each cell holds a three-input, two-output lookup table. Each cell output can be taken straight from the table or from a flip-flop that captures the table output. The routing stage produces two routed signals, and each one picks one of four candidates. Those two routed signals form the low address bits of the second cell.

All 40 configuration bits sit in one serial chain. Software outside the block loads a bit file in two steps. It first pulses a start input. It then presents one data bit per cycle with a step strobe, and each strobe acts as one configuration clock. A done flag reports that exactly 40 bits have been clocked in since the start pulse. After loading, the fabric behaves as the circuit that the bit file describes. The bench loads, for example, a 2-to-4 decoder and a registered half adder.

Top module: `scan_logic_fabric`

## Requirements
- R1: While rst_ni is low, the configuration chain, the cell flip-flops and the bit counter all clear. As a result, out_o reads 0 and cfg_done_o reads 0.
- R2: The chain is indexed 0 to 39. Index 0 is the stage the serial input enters. On a clock edge with cfg_step_i high, cfg_din_i enters index 0 and every index k moves to k+1, so the first of 40 bits ends at index 39. A bit shifted in beyond 40 pushes the oldest bit out.
- R3: cfg_start_i clears the bit counter, and cfg_done_o is low in the next cycle. cfg_done_o rises on the 40th step edge after the start pulse. It stays high through any further steps until the next start pulse. Start wins over a step strobe in the same cycle as far as the counter is concerned.
- R4: On an edge with cfg_step_i low, the configuration does not change, whatever cfg_din_i does.
- R5: The first cell occupies chain indices 0 to 17, the routing stage indices 18 to 21 and the second cell indices 22 to 39. Inside a cell at base b, table word w holds output 1 at b+2w and output 0 at b+2w+1, so output 0 of a word is shifted in before output 1.
- R6: The address of the first cell is {ext_i[0], in_i[1], in_i[0]}. The address of the second cell is {ext_i[1], route1, route0}.
- R7: The select for route0 is {chain[19], chain[18]} and the select for route1 is {chain[21], chain[20]}. Select value 0 picks first-cell output 0, 1 picks first-cell output 1, 2 picks ext_i[0] and 3 picks ext_i[1].
- R8: A path bit at cell index b+16 (for output 0) or b+17 (for output 1) chooses the cell output. With the bit at 1, the output is the table value captured at the previous clock edge. With the bit at 0, the output is the current table value with no delay.
- R9: out_o is {second cell output 1, second cell output 0, first cell output 1, first cell output 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the chain, the counter and the cell flip-flops |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_start_i | input | 1 | Pulse that begins a load and clears the bit counter |
| cfg_step_i | input | 1 | Configuration clock strobe; shifts the chain by one bit |
| cfg_din_i | input | 1 | Serial configuration data |
| cfg_done_o | output | 1 | High once 40 bits have been shifted since the start pulse |
| in_i | input | 2 | Primary inputs, low address bits of the first cell |
| ext_i | input | 2 | External inputs: top address bit of each cell and routing candidates |
| out_o | output | 4 | Both outputs of both cells |

## Verification
The bench loads two bit files: a 2-to-4 decoder built from two combinational cells, and a registered half adder whose outputs are routed into the second cell. It applies every input combination to each.

- **Bit order inside a table word.** A design that reversed the two bits of a word would swap d0 with d1 and d2 with d3.
- **Section order in the chain.** A design that placed the first cell and the second cell the wrong way round would make the decoder produce garbage.
- **Extra leading bit.** The bench shifts in one leading bit before a full bit file, so a chain that failed to drop its oldest bit would be caught.
- **Done flag count.** The flag is sampled after the 39th and the 40th step. A counter that was off by one, or that did not saturate, would show up there.
- **Registered output delay.** The registered outputs are sampled both before and after the clock edge that follows an input change. This exposes a path selector that was inverted or a flip-flop that was bypassed.

// File: rtl/fabric_pkg.sv
package fabric_pkg;
  localparam int LUT_IN     = 3;
  localparam int LUT_W      = 2;
  localparam int LUT_DEPTH  = 1 << LUT_IN;
  localparam int CELL_BITS  = LUT_DEPTH * LUT_W + LUT_W;
  localparam int ROUTES     = LUT_IN - 1;
  localparam int CAND       = 4;
  localparam int SEL_W      = $clog2(CAND);
  localparam int SW_BITS    = ROUTES * SEL_W;
  localparam int CHAIN_BITS = 2 * CELL_BITS + SW_BITS;
  localparam int A_BASE     = 0;
  localparam int SW_BASE    = CELL_BITS;
  localparam int B_BASE     = CELL_BITS + SW_BITS;
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int N = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         din_i,
  output logic [N-1:0] bits_o,
  output logic         done_o
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] FULL = CW'(N);

  logic [N-1:0]  chain_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (step_i) chain_q <= {chain_q[N-2:0], din_i};
      if (start_i) cnt_q <= '0;
      else if (step_i && cnt_q != FULL) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign bits_o = chain_q;
  assign done_o = (cnt_q == FULL);

  // R3
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
  // R3
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(step_i) && !$past(start_i)));
  // R3
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (chain_q[0] == $past(din_i)));
  // R2
  shift_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (chain_q[N-1:1] == $past(chain_q[N-2:0])));
  // R4
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(chain_q));
endmodule

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int IN = 3,
  parameter int W  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [(1<<IN)*W+W-1:0]        cfg_i,
  input  logic [IN-1:0]                 addr_i,
  output logic [W-1:0]                  out_o
);
  localparam int DEPTH    = 1 << IN;
  localparam int PATH_LSB = DEPTH * W;

  logic [W-1:0] word_raw;
  logic [W-1:0] lut_d;
  logic [W-1:0] lut_q;

  assign word_raw = cfg_i[int'(addr_i)*W +: W];

  for (genvar j = 0; j < W; j++) begin : g_out
    // output 0 sits at the upper position of each word
    assign lut_d[j] = word_raw[W-1-j];
    assign out_o[j] = cfg_i[PATH_LSB + j] ? lut_q[j] : lut_d[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lut_q <= '0;
    else         lut_q <= lut_d;
  end
endmodule

// File: rtl/route_mux.sv
module route_mux #(
  parameter int ROUTES = 2,
  parameter int CAND   = 4
) (
  input  logic [CAND-1:0]                  cand_i,
  input  logic [ROUTES*$clog2(CAND)-1:0]   sel_cfg_i,
  output logic [ROUTES-1:0]                route_o
);
  localparam int SW = $clog2(CAND);

  for (genvar r = 0; r < ROUTES; r++) begin : g_route
    logic [SW-1:0] sel;
    assign sel        = sel_cfg_i[r*SW +: SW];
    assign route_o[r] = cand_i[sel];
  end
endmodule

// File: rtl/scan_logic_fabric.sv
module scan_logic_fabric
  import fabric_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_start_i,
  input  logic       cfg_step_i,
  input  logic       cfg_din_i,
  output logic       cfg_done_o,
  input  logic [1:0] in_i,
  input  logic [1:0] ext_i,
  output logic [3:0] out_o
);
  logic [CHAIN_BITS-1:0] cfg;
  logic [LUT_W-1:0]      a_out;
  logic [LUT_W-1:0]      b_out;
  logic [ROUTES-1:0]     route;

  cfg_chain #(.N(CHAIN_BITS)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cfg_start_i),
    .step_i  (cfg_step_i),
    .din_i   (cfg_din_i),
    .bits_o  (cfg),
    .done_o  (cfg_done_o)
  );

  lut_cell #(.IN(LUT_IN), .W(LUT_W)) u_cell_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg[A_BASE +: CELL_BITS]),
    .addr_i ({ext_i[0], in_i}),
    .out_o  (a_out)
  );

  // candidates: a_out[0], a_out[1], ext_i[0], ext_i[1]
  route_mux #(.ROUTES(ROUTES), .CAND(CAND)) u_switch (
    .cand_i    ({ext_i, a_out}),
    .sel_cfg_i (cfg[SW_BASE +: SW_BITS]),
    .route_o   (route)
  );

  lut_cell #(.IN(LUT_IN), .W(LUT_W)) u_cell_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg[B_BASE +: CELL_BITS]),
    .addr_i ({ext_i[1], route}),
    .out_o  (b_out)
  );

  assign out_o = {b_out, a_out};
endmodule

// File: tb/scan_logic_fabric_tb_top.sv
module scan_logic_fabric_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       start_r = 1'b0;
  logic       step_r = 1'b0;
  logic       din_r = 1'b0;
  logic [1:0] in_r = 2'b00;
  logic [1:0] ext_r = 2'b00;
  logic       done_w;
  logic [3:0] out_w;

  int    vectors = 0;
  int    fails = 0;
  bit    running = 1'b0;
  string phase = "R1";

  // behavioural reference state
  logic [39:0] m_cfg = '0;
  int          m_cnt = 0;
  logic [1:0]  m_ra = '0;
  logic [1:0]  m_rb = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_logic_fabric dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cfg_start_i (start_r),
    .cfg_step_i  (step_r),
    .cfg_din_i   (din_r),
    .cfg_done_o  (done_w),
    .in_i        (in_r),
    .ext_i       (ext_r),
    .out_o       (out_w)
  );

  function automatic logic [1:0] word_at(logic [39:0] c, int base, int addr);
    return {c[base + 2*addr], c[base + 2*addr + 1]};
  endfunction

  function automatic void model_eval(input logic [39:0] c, input logic [1:0] in_v,
                                     input logic [1:0] ext_v, input logic [1:0] ra,
                                     input logic [1:0] rb, output logic [1:0] la,
                                     output logic [1:0] lb, output logic [3:0] o);
    logic [1:0] ao, bo, m;
    logic [3:0] cand;
    la = word_at(c, 0, {ext_v[0], in_v});
    ao[0] = c[16] ? ra[0] : la[0];
    ao[1] = c[17] ? ra[1] : la[1];
    cand = {ext_v[1], ext_v[0], ao[1], ao[0]};
    m[0] = cand[{c[19], c[18]}];
    m[1] = cand[{c[21], c[20]}];
    lb = word_at(c, 22, {ext_v[1], m});
    bo[0] = c[38] ? rb[0] : lb[0];
    bo[1] = c[39] ? rb[1] : lb[1];
    o = {bo, ao};
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    logic [1:0] la, lb;
    logic [3:0] o;
    if (!rst_ni) begin
      m_cfg = '0; m_cnt = 0; m_ra = '0; m_rb = '0;
    end else begin
      model_eval(m_cfg, in_r, ext_r, m_ra, m_rb, la, lb, o);
      m_ra = la;
      m_rb = lb;
      if (step_r) m_cfg = {m_cfg[38:0], din_r};
      if (start_r) m_cnt = 0;
      else if (step_r && m_cnt != 40) m_cnt++;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [1:0] la, lb;
    logic [3:0] o;
    if (running) begin
      model_eval(m_cfg, in_r, ext_r, m_ra, m_rb, la, lb, o);
      vectors++;
      if (out_w !== o) begin
        fails++;
        $display("FAIL %s out_o actual=%b expected=%b", phase, out_w, o);
      end
      vectors++;
      if (done_w !== (m_cnt == 40)) begin
        fails++;
        $display("FAIL %s cfg_done_o actual=%b expected=%b", phase, done_w, (m_cnt == 40));
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // 0: 2-to-4 decoder, 1: registered half adder routed into cell B
  function automatic logic [39:0] build_image(int id);
    logic [39:0] c = '0;
    for (int w = 0; w < 8; w++) begin
      logic [1:0] a, b;
      if (id == 0) begin
        a = {w[1:0] == 2'd1, w[1:0] == 2'd0};
        b = {w[1:0] == 2'd3, w[1:0] == 2'd2};
      end else begin
        a = {w[1] & w[0], w[1] ^ w[0]};
        b = {w[1] | w[2], w[0]};
      end
      c[2*w]          = a[1];
      c[2*w + 1]      = a[0];
      c[22 + 2*w]     = b[1];
      c[22 + 2*w + 1] = b[0];
    end
    if (id == 0) begin
      {c[19], c[18]} = 2'd2;
      {c[21], c[20]} = 2'd3;
    end else begin
      c[16] = 1'b1; c[17] = 1'b1;
      {c[19], c[18]} = 2'd0;
      {c[21], c[20]} = 2'd1;
    end
    return c;
  endfunction

  task automatic load_image(logic [39:0] img, bit lead_bit);
    start_r = 1'b1; tick(); start_r = 1'b0;
    chk("R3 done cleared by start", done_w, 0);
    if (lead_bit) begin
      step_r = 1'b1; din_r = 1'b1; tick();
    end
    for (int k = 39; k >= 0; k--) begin
      step_r = 1'b1; din_r = img[k]; tick();
      if (!lead_bit && k == 1) chk("R3 done low after 39 steps", done_w, 0);
    end
    step_r = 1'b0; din_r = 1'b0;
    chk("R3 done high after 40 steps", done_w, 1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    #1 rst_ni = 1'b0;
    running = 1'b1;
    tick(); tick();
    chk("R1 out_o in reset", out_w, 0);
    chk("R1 done in reset", done_w, 0);
    rst_ni = 1'b1; tick();
    chk("R1 out_o after reset", out_w, 0);

    phase = "R2 R3 R5 load decoder";
    load_image(build_image(0), 1'b0);
    step_r = 1'b1; din_r = 1'b1; tick();
    chk("R3 done stays high on extra step", done_w, 1);
    step_r = 1'b0; din_r = 1'b0;
    phase = "R3 restart";
    start_r = 1'b1; tick(); start_r = 1'b0;
    chk("R3 restart clears done", done_w, 0);

    phase = "R2 reload with leading bit";
    load_image(build_image(0), 1'b1);

    phase = "R5 R6 R7 R9 decoder";
    for (int v = 0; v < 4; v++) begin
      in_r = 2'(v); ext_r = 2'(v); tick();
      chk("R5 R6 R7 R9 decoder one-hot", out_w, 32'(1) << v);
    end

    phase = "R4 idle chain";
    for (int t = 0; t < 8; t++) begin
      din_r = ~din_r; in_r = 2'(t); ext_r = 2'(t); tick();
      chk("R4 config unchanged without step", out_w, 32'(1) << (t % 4));
    end
    din_r = 1'b0;

    phase = "R8 R7 registered adder";
    load_image(build_image(1), 1'b0);
    in_r = 2'b00; ext_r = 2'b00; tick(); tick();
    chk("R8 adder idle", out_w, 0);
    in_r = 2'b01; #1;
    chk("R8 registered output lags", out_w[0], 0);
    tick();
    chk("R8 sum after edge", out_w, 4'b0101);
    in_r = 2'b11; tick();
    chk("R8 R7 carry routed to cell B", out_w, 4'b1010);
    ext_r = 2'b10; tick();
    chk("R6 ext1 reaches cell B address", out_w, 4'b1010);
    in_r = 2'b10; ext_r = 2'b00; tick();
    chk("R8 R7 sum routed to cell B", out_w, 4'b0101);

    tick();
    running = 1'b0;
    finish_run();
  end
endmodule